// File: doc/BRIEF.md
# Nine-Bit Multidrop Receive Address Filter

This block sits between a UART receive deserializer and the receive FIFO. It adds nine-bit multidrop addressing. On a multidrop bus, a master sends an address character and then data characters meant for the addressed station. The ninth bit of each character, which occupies the parity slot, tells the two kinds apart. A one marks an address and a zero marks data.

When the mode is on, the filter always passes address characters to the FIFO, flags them as parity errors and raises a line-status interrupt. Data characters are dropped unless the host has set the receive-enable input. Software reads each address and compares it with its own station ID. It then sets or clears receive-enable, so only the data meant for this station reaches the FIFO. Matching the address is the host's job. Baud timing and sampling happen upstream. Special-character detection and both kinds of flow control must be off while the mode is in use.

When the mode is off, every character passes through unchanged with no parity flag. A full FIFO is never overwritten: the character is dropped and a sticky overrun flag is set instead.

Top module: `mdrop_addr_filter`

## Requirements
- R1: During and directly after synchronous reset, `push`, `push_perr`, `push_ferr`, `overrun` and `lsi_irq` are all 0.
- R2: With `mode_en`=0, every received character is pushed with `push_perr`=0, whatever its ninth bit and whatever `rcv_en` is.
- R3: With `mode_en`=1 and `rcv_en`=0, a character whose ninth bit is 0 is never pushed.
- R4: With `mode_en`=1, a character whose ninth bit is 1 is pushed with `push_perr`=1, whether `rcv_en` is 0 or 1.
- R5: With `mode_en`=1 and `rcv_en`=1, a character whose ninth bit is 0 is pushed with `push_perr`=0.
- R6: `push_ferr` copies the framing-error input of each pushed character. A data character with a framing error that R3 drops is still not pushed, and it raises no interrupt.
- R7: A character that is accepted on the cycle `rx_valid` is 1 gives `push`=1 on the next cycle, with `push_data` equal to `rx_data`. Accepted characters on back-to-back cycles are all delivered.
- R8: A character that would be pushed while `fifo_full`=1 is not pushed. Instead `overrun` becomes 1 on the next cycle and stays 1 until `lsr_read` is pulsed.
- R9: An interrupt becomes pending the cycle after a pushed character with `push_perr` or `push_ferr` set, or after an overrun. It stays pending until `lsr_read`. If a new event and `lsr_read` arrive in the same cycle, the event wins.
- R10: `lsi_irq` equals the pending state ANDed with `lsi_en`. Changing `lsi_en` changes the output in the same cycle and leaves the pending state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Nine-bit multidrop mode enable |
| rcv_en | input | 1 | Host-controlled receive enable for data characters |
| lsi_en | input | 1 | Line-status interrupt enable |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_data | input | DATA_W | Received character payload |
| rx_bit9 | input | 1 | Ninth bit (1 = address, 0 = data) |
| rx_ferr | input | 1 | Framing error on this character |
| fifo_full | input | 1 | Receive FIFO cannot accept a character |
| lsr_read | input | 1 | Host read of line status; clears overrun and pending interrupt |
| push | output | 1 | FIFO write strobe |
| push_data | output | DATA_W | Character written to the FIFO |
| push_perr | output | 1 | Parity-error flag stored with the character (address marker) |
| push_ferr | output | 1 | Framing-error flag stored with the character |
| overrun | output | 1 | Sticky overrun flag |
| lsi_irq | output | 1 | Line-status interrupt request |

## Verification
The bench builds the block with its default `DATA_W` of 8. At that width a character sent in a directed test can be recognised in `push_data`, and a random payload covers every byte value. The width has no effect on the filtering decision, so every branch of the filter is reachable at 8 bits: address or data, receive enabled or not, mode on or off, FIFO full or not. This includes the same-cycle collision between an interrupt event and a status read, and the case of a dropped data character that also has a framing error.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    // Decision taken for one received character
    typedef struct packed {
        logic keep;   // character is meant for the FIFO
        logic perr;   // stored parity-error flag (address marker)
        logic ferr;   // stored framing-error flag
    } verdict_t;

    function automatic verdict_t classify(input logic mode,
                                          input logic rcv,
                                          input logic bit9,
                                          input logic ferr);
        verdict_t v;
        v.keep = mode ? (bit9 | rcv) : 1'b1;
        v.perr = mode & bit9;
        v.ferr = ferr;
        return v;
    endfunction

    function automatic logic line_event(input verdict_t v, input logic full);
        return v.keep & (v.perr | v.ferr | full);
    endfunction

endpackage

// File: rtl/mdrop_classify.sv
module mdrop_classify
    import mdrop_pkg::*;
(
    input  logic     mode_en,
    input  logic     rcv_en,
    input  logic     rx_bit9,
    input  logic     rx_ferr,
    output verdict_t verdict
);
    always_comb verdict = classify(mode_en, rcv_en, rx_bit9, rx_ferr);
endmodule

// File: rtl/mdrop_push_stage.sv
module mdrop_push_stage
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  verdict_t          verdict,
    input  logic              fifo_full,
    input  logic              lsr_read,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              push_perr,
    output logic              push_ferr,
    output logic              overrun
);
    logic accept, do_push, ovr_hit;

    always_comb begin
        accept  = rx_valid & verdict.keep;
        do_push = accept & ~fifo_full;
        ovr_hit = accept & fifo_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push      <= 1'b0;
            push_perr <= 1'b0;
            push_ferr <= 1'b0;
            push_data <= '0;
        end else begin
            push      <= do_push;
            push_perr <= do_push & verdict.perr;
            push_ferr <= do_push & verdict.ferr;
            if (do_push) push_data <= rx_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           overrun <= 1'b0;
        else if (ovr_hit)  overrun <= 1'b1;
        else if (lsr_read) overrun <= 1'b0;
    end

    // R8
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fifo_full) |=> !push);
    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !lsr_read) |=> overrun);
    // R7
    push_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> $past(rx_valid));
endmodule

// File: rtl/mdrop_lsi_ctrl.sv
module mdrop_lsi_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic line_evt,
    input  logic lsr_read,
    input  logic lsi_en,
    output logic lsi_irq
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst)           pend <= 1'b0;
        else if (line_evt) pend <= 1'b1;
        else if (lsr_read) pend <= 1'b0;
    end

    assign lsi_irq = pend & lsi_en;

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (lsr_read && !line_evt) |=> !lsi_irq);
    // R9
    event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (line_evt && lsi_en) |=> (lsi_irq || !lsi_en));
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_en,
    input  logic              rcv_en,
    input  logic              lsi_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_bit9,
    input  logic              rx_ferr,
    input  logic              fifo_full,
    input  logic              lsr_read,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              push_perr,
    output logic              push_ferr,
    output logic              overrun,
    output logic              lsi_irq
);
    verdict_t verdict;
    logic     line_evt;

    mdrop_classify u_classify (
        .mode_en (mode_en),
        .rcv_en  (rcv_en),
        .rx_bit9 (rx_bit9),
        .rx_ferr (rx_ferr),
        .verdict (verdict)
    );

    assign line_evt = rx_valid & line_event(verdict, fifo_full);

    mdrop_push_stage #(.DATA_W(DATA_W)) u_push (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .verdict   (verdict),
        .fifo_full (fifo_full),
        .lsr_read  (lsr_read),
        .push      (push),
        .push_data (push_data),
        .push_perr (push_perr),
        .push_ferr (push_ferr),
        .overrun   (overrun)
    );

    mdrop_lsi_ctrl u_lsi (
        .clk      (clk),
        .rst      (rst),
        .line_evt (line_evt),
        .lsr_read (lsr_read),
        .lsi_en   (lsi_en),
        .lsi_irq  (lsi_irq)
    );

    // R3
    drop_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && mode_en && !rcv_en && !rx_bit9) |=> !push);
    // R4
    address_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && mode_en && rx_bit9 && !fifo_full) |=> (push && push_perr));
    // R2
    plain_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !mode_en && !fifo_full) |=> (push && !push_perr));
endmodule

// File: tb/test_mdrop_addr_filter.sv
module test_mdrop_addr_filter;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_en = 0, rcv_en = 0, lsi_en = 0, rx_valid = 0, rx_bit9 = 0;
    logic rx_ferr = 0, fifo_full = 0, lsr_read = 0;
    logic [DATA_W-1:0] rx_data = '0;
    logic push, push_perr, push_ferr, overrun, lsi_irq;
    logic [DATA_W-1:0] push_data;

    int checks = 0, errors = 0, cycles = 0;
    string tag = "R1";

    // reference state
    bit e_push, e_perr, e_ferr, e_ovr, e_pend;
    logic [DATA_W-1:0] e_data;

    always #5 clk = ~clk;

    mdrop_addr_filter #(.DATA_W(DATA_W)) i_mdrop_addr_filter (
        .clk(clk), .rst(rst), .mode_en(mode_en), .rcv_en(rcv_en), .lsi_en(lsi_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_ferr(rx_ferr),
        .fifo_full(fifo_full), .lsr_read(lsr_read), .push(push), .push_data(push_data),
        .push_perr(push_perr), .push_ferr(push_ferr), .overrun(overrun), .lsi_irq(lsi_irq)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Advance one clock: model the next state from the current inputs, then compare.
    task automatic tick();
        bit wanted, stored, evt;
        if (rst) begin
            e_push = 0; e_perr = 0; e_ferr = 0; e_ovr = 0; e_pend = 0;
        end else begin
            if (!mode_en) wanted = rx_valid;
            else if (rx_bit9) wanted = rx_valid;
            else wanted = rx_valid && rcv_en;
            stored = wanted && !fifo_full;
            evt = wanted && ((mode_en && rx_bit9) || rx_ferr || fifo_full);
            e_push = stored;
            e_perr = stored && mode_en && rx_bit9;
            e_ferr = stored && rx_ferr;
            if (stored) e_data = rx_data;
            if (wanted && fifo_full) e_ovr = 1;
            else if (lsr_read) e_ovr = 0;
            if (evt) e_pend = 1;
            else if (lsr_read) e_pend = 0;
        end
        @(posedge clk);
        #2;
        cycles++;
        chk("push", push, e_push);
        if (e_push) begin
            chk("push_data", push_data, e_data);
            chk("push_perr", push_perr, e_perr);
            chk("push_ferr", push_ferr, e_ferr);
        end
        chk("overrun", overrun, e_ovr);
        chk("lsi_irq", lsi_irq, e_pend && lsi_en);
    endtask

    task automatic send(input logic [DATA_W-1:0] d, input logic b9, input logic fe);
        rx_valid = 1; rx_data = d; rx_bit9 = b9; rx_ferr = fe;
        tick();
        rx_valid = 0; rx_bit9 = 0; rx_ferr = 0;
    endtask

    task automatic read_lsr();
        lsr_read = 1; tick(); lsr_read = 0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tag = "R1";
        lsi_en = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        chk("push_perr", push_perr, 0);
        chk("push_ferr", push_ferr, 0);

        tag = "R2";
        mode_en = 0; rcv_en = 0;
        send(8'h11, 0, 0); send(8'h22, 1, 0); send(8'h33, 1, 0);
        tick();

        tag = "R3";
        mode_en = 1; rcv_en = 0;
        send(8'h44, 0, 0); send(8'h45, 0, 0);
        tick();
        chk("lsi_irq idle", lsi_irq, 0);

        tag = "R4";
        send(8'hA1, 1, 0);
        chk("address stored", push, 1);
        read_lsr();
        rcv_en = 1;
        send(8'hA2, 1, 0);
        chk("address perr", push_perr, 1);
        read_lsr();

        tag = "R5";
        send(8'h51, 0, 0); send(8'h52, 0, 0);
        chk("data last", push_data, 8'h52);
        chk("no irq for clean data", lsi_irq, 0);

        tag = "R6";
        send(8'h61, 0, 1);
        chk("ferr stored", push_ferr, 1);
        read_lsr();
        rcv_en = 0;
        send(8'h62, 0, 1);
        chk("ferr data dropped", push, 0);
        tick();
        chk("no irq for dropped", lsi_irq, 0);

        tag = "R7";
        rcv_en = 1;
        for (int i = 0; i < 6; i++) begin
            rx_valid = 1; rx_data = 8'(8'h70 + i); rx_bit9 = (i == 3); rx_ferr = 0;
            tick();
        end
        rx_valid = 0; rx_bit9 = 0;
        tick();
        read_lsr();

        tag = "R8";
        fifo_full = 1;
        send(8'h81, 0, 0);
        chk("overrun set", overrun, 1);
        fifo_full = 0;
        repeat (3) tick();
        chk("overrun held", overrun, 1);
        read_lsr();
        chk("overrun cleared", overrun, 0);

        tag = "R9";
        send(8'h91, 1, 0);
        tick();
        lsr_read = 1; rx_valid = 1; rx_data = 8'h92; rx_bit9 = 1;
        tick();
        lsr_read = 0; rx_valid = 0; rx_bit9 = 0;
        chk("event beats read", lsi_irq, 1);
        read_lsr();
        chk("read clears", lsi_irq, 0);

        tag = "R10";
        send(8'hB0, 1, 0);
        lsi_en = 0; tick();
        chk("gated", lsi_irq, 0);
        lsi_en = 1; tick();
        chk("ungated", lsi_irq, 1);
        read_lsr();

        tag = "R7";
        for (int i = 0; i < 400; i++) begin
            mode_en = ($urandom % 4) != 0;
            rcv_en = $urandom % 2;
            lsi_en = ($urandom % 4) != 0;
            rx_valid = $urandom % 2;
            rx_data = 8'($urandom);
            rx_bit9 = ($urandom % 3) == 0;
            rx_ferr = ($urandom % 8) == 0;
            fifo_full = ($urandom % 6) == 0;
            lsr_read = ($urandom % 5) == 0;
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule